// File: doc/BRIEF.md
# Offset-Corrected Energy Accumulator

This block turns a stream of paired, signed voltage and current samples into an energy figure. Each pair is multiplied to form an instantaneous power value. The product is rounded back to the sample format. A programmable signed correction term is then added, and the result is clamped to full scale. These corrected power values are summed over a period of N sample pairs. At the end of each period the total is published on the energy output and a one-cycle done strobe fires.

The correction term is applied to every single power value, not once to the finished total. A negative correction therefore removes a steady parasitic contribution in proportion to the number of samples taken. The correction is held in a 24-bit register written through a simple write-enable port. The period length comes from a plain input that the surrounding logic drives.

Top module: `eacc_energy_accum`

## Requirements
- R1: After reset, `energy_out` is 0, `period_done` is 0, and the power offset is 0. With offset 0, the first period's result equals the plain sum of rounded products.
- R2: Samples and the offset are signed Q0.23 values (bit 23 is the sign with weight -1, bit 0 has weight 2^-23). The 48-bit product is rounded to Q0.23 by adding 2^22 to the raw product and shifting right arithmetically by 23, which rounds halves upward.
- R3: The offset is added to every rounded product, once per sample pair, before accumulation. A period's energy equals the sum of the N corrected values, in units of 2^-23.
- R4: A negative (two's-complement) offset is supported and lowers each per-sample value by its magnitude.
- R5: The corrected per-sample value saturates to the range [-2^23, 2^23-1]. This applies to (-1)×(-1) and to any offset that pushes the value past full scale.
- R6: A period closes on the sample pair that brings the count of accepted pairs to `period_len`. A `period_len` of 0 acts as 1. On the second rising edge after that pair is accepted, `energy_out` takes the period total and `period_done` is high for exactly that one cycle. The next period starts from zero.
- R7: The accumulator is wide enough (sample width plus count width) that `period_len` full-scale values cannot wrap. For example, 64 values of 2^23-1 give exactly 536870848.
- R8: An offset written on the same edge that accepts a sample pair does not apply to that pair. It applies to every later pair, and the partial sum already built is kept unchanged.
- R9: Cycles with `smp_valid` low neither count toward the period nor change the sum. `energy_out` holds its value between period closings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample pair is present this cycle |
| v_smp | input | 24 | Voltage sample, signed Q0.23 |
| i_smp | input | 24 | Current sample, signed Q0.23 |
| ofs_wr_en | input | 1 | Load `ofs_wr_data` into the offset register |
| ofs_wr_data | input | 24 | New power offset, signed Q0.23 |
| period_len | input | 16 | Sample pairs per accumulation period (0 acts as 1) |
| energy_out | output | 40 | Total of the last completed period, signed, units of 2^-23 |
| period_done | output | 1 | One-cycle pulse when `energy_out` is refreshed |

## Verification
The embedded assertions check three things on every cycle. They confirm that an accepted pair produces a power value exactly one cycle later. They confirm that the done strobe only follows an accumulated value, and that the output and the running sum stay still when no value arrives. They also confirm that a written offset is the one held afterwards.

Only the directed scenarios can show the numbers themselves. These are the rounding of halves, the saturation corners, the effect of negative offsets, and the wide totals of long periods. The same is true of the exact edge at which an offset write starts to count against a period in progress.

// File: rtl/eacc_pkg.sv
// Package: shared helpers for the energy accumulator.
// Assumes every clamped quantity fits in 64 signed bits.
package eacc_pkg;

    // Clamp a signed value to the range of a w-bit two's-complement number.
    function automatic logic signed [63:0] clamp_s(input logic signed [63:0] x, input int w);
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (x > hi)      clamp_s = hi;
        else if (x < lo) clamp_s = lo;
        else             clamp_s = x;
    endfunction

endpackage

// File: rtl/eacc_offset_reg.sv
// Module: power offset register.
// Holds the signed per-sample correction. It loads on a write strobe and clears on reset.
// Assumes writes arrive as single-cycle strobes.
module eacc_offset_reg #(
    parameter int SMP_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic signed [SMP_W-1:0] wr_data,
    output logic signed [SMP_W-1:0] ofs_q
);

    // Load a new offset or keep the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)     ofs_q <= '0;
        else if (wr_en) ofs_q <= wr_data;
    end

    // R8
    ofs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ofs_q == $past(wr_data)));

endmodule

// File: rtl/eacc_power_stage.sv
// Module: per-sample power stage.
// Multiplies one voltage/current pair and rounds the product back to sample format.
// It then adds the offset and clamps the result to full scale. One register stage.
// Assumes SMP_W <= 31 so that all intermediate values fit in 64 bits.
module eacc_power_stage #(
    parameter int SMP_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] v_smp,
    input  logic signed [SMP_W-1:0] i_smp,
    input  logic signed [SMP_W-1:0] ofs,
    output logic                    pw_vld,
    output logic signed [SMP_W-1:0] pw
);
    import eacc_pkg::*;

    localparam int PROD_W = 2 * SMP_W;
    localparam int FRAC   = SMP_W - 1;
    localparam logic signed [PROD_W:0] HALF = (PROD_W + 1)'(1) << (FRAC - 1);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W:0]   prod_rnd;
    logic signed [PROD_W:0]   sum_wide;
    logic signed [63:0]       sum_ext;
    logic signed [SMP_W-1:0]  pw_nx;

    // Form the rounded, offset-corrected and clamped power value.
    always_comb begin
        prod     = v_smp * i_smp;
        prod_rnd = ((PROD_W + 1)'(prod) + HALF) >>> FRAC;
        sum_wide = prod_rnd + (PROD_W + 1)'(ofs);
        sum_ext  = 64'(sum_wide);
        pw_nx    = SMP_W'(clamp_s(sum_ext, SMP_W));
    end

    // Register the corrected value together with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_vld <= 1'b0;
            pw     <= '0;
        end else begin
            pw_vld <= smp_valid;
            if (smp_valid) pw <= pw_nx;
        end
    end

    // R3
    pw_follows_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> pw_vld);

    // R9
    pw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!pw_vld && $stable(pw)));

endmodule

// File: rtl/eacc_accum.sv
// Module: period accumulator.
// Sums corrected power values and counts them. When the count reaches the
// period length it publishes the total, pulses done and restarts from zero.
// Assumes a period length of 0 means 1.
module eacc_accum #(
    parameter int SMP_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pw_vld,
    input  logic signed [SMP_W-1:0]       pw,
    input  logic [CNT_W-1:0]              period_len,
    output logic signed [SMP_W+CNT_W-1:0] energy,
    output logic                          done
);
    localparam int ACC_W = SMP_W + CNT_W;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_nx;
    logic [CNT_W-1:0]        cnt_q;
    logic                    last;

    // Next sum, and the test for the period's closing pair.
    always_comb begin
        acc_nx = acc_q + ACC_W'(pw);
        last   = ({1'b0, cnt_q} + (CNT_W + 1)'(1)) >= {1'b0, period_len};
    end

    // Accumulate, count, and publish at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            energy <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (pw_vld) begin
                if (last) begin
                    energy <= acc_nx;
                    acc_q  <= '0;
                    cnt_q  <= '0;
                    done   <= 1'b1;
                end else begin
                    acc_q <= acc_nx;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R6
    done_after_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pw_vld));

    // R9
    energy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(energy));

    // R9
    acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pw_vld |=> ($stable(acc_q) && $stable(cnt_q)));

endmodule

// File: rtl/eacc_energy_accum.sv
// Module: offset-corrected energy accumulator (top).
// Chains the offset register, the per-sample power stage and the period accumulator.
// Assumes inputs are synchronous to clk. A total shows two edges after its last pair.
module eacc_energy_accum #(
    parameter int SMP_W = 24,
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_valid,
    input  logic signed [SMP_W-1:0]       v_smp,
    input  logic signed [SMP_W-1:0]       i_smp,
    input  logic                          ofs_wr_en,
    input  logic signed [SMP_W-1:0]       ofs_wr_data,
    input  logic [CNT_W-1:0]              period_len,
    output logic signed [SMP_W+CNT_W-1:0] energy_out,
    output logic                          period_done
);

    logic signed [SMP_W-1:0] ofs_q;
    logic                    pw_vld;
    logic signed [SMP_W-1:0] pw;

    eacc_offset_reg #(.SMP_W(SMP_W)) ofs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ofs_wr_en),
        .wr_data (ofs_wr_data),
        .ofs_q   (ofs_q)
    );

    eacc_power_stage #(.SMP_W(SMP_W)) pwr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .v_smp     (v_smp),
        .i_smp     (i_smp),
        .ofs       (ofs_q),
        .pw_vld    (pw_vld),
        .pw        (pw)
    );

    eacc_accum #(.SMP_W(SMP_W), .CNT_W(CNT_W)) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pw_vld     (pw_vld),
        .pw         (pw),
        .period_len (period_len),
        .energy     (energy_out),
        .done       (period_done)
    );

endmodule

// File: tb/eacc_energy_accum_tb_top.sv
// Bench: directed scenarios for the offset-corrected energy accumulator.
// Inputs are driven on falling edges and outputs are sampled on falling edges.
module eacc_energy_accum_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SMP_W = 24;
    localparam int CNT_W = 16;
    localparam int ACC_W = SMP_W + CNT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [SMP_W-1:0] v_smp = '0;
    logic signed [SMP_W-1:0] i_smp = '0;
    logic ofs_wr_en = 1'b0;
    logic signed [SMP_W-1:0] ofs_wr_data = '0;
    logic [CNT_W-1:0] period_len = '0;
    logic signed [ACC_W-1:0] energy_out;
    logic period_done;

    int n_run = 0;
    int n_fail = 0;

    localparam longint FS_POS = 64'sd8388607;
    localparam longint FS_NEG = -64'sd8388608;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eacc_energy_accum #(.SMP_W(SMP_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .v_smp(v_smp), .i_smp(i_smp),
        .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data), .period_len(period_len),
        .energy_out(energy_out), .period_done(period_done)
    );

    // Expected corrected per-sample value from R2, R3 and R5.
    function automatic longint exp_pw(longint v, longint i, longint o);
        longint p;
        longint r;
        p = v * i;
        r = (p + 64'sd4194304) >>> 23;
        r = r + o;
        if (r > FS_POS) r = FS_POS;
        if (r < FS_NEG) r = FS_NEG;
        return r;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_ofs(input longint o);
        @(negedge clk);
        ofs_wr_en = 1'b1;
        ofs_wr_data = SMP_W'(o);
        @(negedge clk);
        ofs_wr_en = 1'b0;
    endtask

    // One sample pair, valid for one cycle, followed by one idle cycle.
    task automatic send(input longint v, input longint i);
        @(negedge clk);
        smp_valid = 1'b1;
        v_smp = SMP_W'(v);
        i_smp = SMP_W'(i);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Step past the accumulator edge after the last send, then check the result.
    task automatic expect_done(input string req, input longint exp);
        @(negedge clk);
        check(req, longint'(period_done), 1);
        check(req, longint'(energy_out), exp);
        @(negedge clk);
        check({req, " pulse width"}, longint'(period_done), 0);
    endtask

    task automatic t_reset;
        check("R1 energy", longint'(energy_out), 0);
        check("R1 done", longint'(period_done), 0);
        period_len = 16'd2;
        send(64'sd4194304, 64'sd4194304);
        send(-64'sd2097152, 64'sd4194304);
        expect_done("R1 zero offset", exp_pw(4194304, 4194304, 0) + exp_pw(-2097152, 4194304, 0));
    endtask

    task automatic t_round;
        // 2^-23 * 2^22: 0.5 LSB rounds up to 1; (-1 LSB) * 2^22: -0.5 rounds up to 0.
        period_len = 16'd1;
        send(64'sd1, 64'sd4194304);
        expect_done("R2 half up", 1);
        send(-64'sd1, 64'sd4194304);
        expect_done("R2 neg half", 0);
        send(64'sd3, 64'sd1398101);
        expect_done("R2 general", exp_pw(3, 1398101, 0));
    endtask

    task automatic t_offset;
        period_len = 16'd3;
        set_ofs(64'sd1000);
        send(64'sd100000, 64'sd200000);
        send(64'sd0, 64'sd0);
        send(-64'sd300000, 64'sd50000);
        expect_done("R3 per-sample offset",
            exp_pw(100000, 200000, 1000) + 1000 + exp_pw(-300000, 50000, 1000));
        set_ofs(-64'sd5000);
        send(64'sd0, 64'sd0);
        send(64'sd2000000, 64'sd3000000);
        send(64'sd0, 64'sd0);
        expect_done("R4 negative offset", -5000 + exp_pw(2000000, 3000000, -5000) - 5000);
    endtask

    task automatic t_sat;
        period_len = 16'd1;
        set_ofs(0);
        send(FS_NEG, FS_NEG);
        expect_done("R5 minus one squared", FS_POS);
        set_ofs(-64'sd100);
        send(FS_NEG, FS_POS);
        expect_done("R5 negative clamp", FS_NEG);
        set_ofs(64'sd8000000);
        send(64'sd4194304, 64'sd4194304);
        expect_done("R5 positive clamp", FS_POS);
    endtask

    task automatic t_period;
        set_ofs(0);
        period_len = 16'd0;
        send(64'sd8, 64'sd1048576);
        expect_done("R6 zero length", 1);
        period_len = 16'd4;
        for (int k = 0; k < 4; k++) send(64'sd16, 64'sd1048576);
        expect_done("R6 four pairs", 8);
        // Back-to-back pairs with no gap.
        period_len = 16'd2;
        @(negedge clk);
        smp_valid = 1'b1; v_smp = 24'sd32; i_smp = 24'sd1048576;
        @(negedge clk);
        v_smp = 24'sd64;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R6 not yet", longint'(period_done), 0);
        expect_done("R6 back-to-back", 12);
    endtask

    task automatic t_wide;
        period_len = 16'd64;
        set_ofs(64'sd200);
        for (int k = 0; k < 64; k++) send(FS_NEG, FS_NEG);
        expect_done("R7 no wrap", 64 * FS_POS);
    endtask

    task automatic t_ofs_timing;
        period_len = 16'd3;
        set_ofs(0);
        send(64'sd100000, 64'sd100000);
        @(negedge clk);
        smp_valid = 1'b1; v_smp = 24'sd100000; i_smp = 24'sd100000;
        ofs_wr_en = 1'b1; ofs_wr_data = 24'sd7;
        @(negedge clk);
        smp_valid = 1'b0; ofs_wr_en = 1'b0;
        send(64'sd100000, 64'sd100000);
        expect_done("R8 write timing", 3 * exp_pw(100000, 100000, 0) + 7);
    endtask

    task automatic t_hold;
        longint held;
        period_len = 16'd2;
        set_ofs(0);
        send(64'sd1024, 64'sd8192);
        repeat (10) @(negedge clk);
        check("R9 idle no close", longint'(period_done), 0);
        held = longint'(energy_out);
        send(64'sd1024, 64'sd8192);
        expect_done("R9 idle ignored", 2);
        check("R9 hold changed", (held == 3 * exp_pw(100000, 100000, 0) + 7) ? 1 : 0, 1);
        repeat (5) @(negedge clk);
        check("R9 hold after", longint'(energy_out), 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_round();
        t_offset();
        t_sat();
        t_period();
        t_wide();
        t_ofs_timing();
        t_hold();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule